// File: doc/BRIEF.md
# Interval Trigger Generator

This block produces single-cycle trigger pulses that pace the updates of a digital-to-analog converter. It has two selectable sources behind one enable. In counter mode, a 16-bit interval counter is armed and cleared by a start pulse. It advances on each prescaled count tick and emits a pulse every time it has counted the programmed number of ticks, then wraps to zero and keeps running. In bypass mode, the counter is idle and each rising edge on an external trigger line produces exactly one output pulse.

The start pulse, the count tick and the external trigger line come from neighbouring logic. The start pulse is the already-selected start event: a hardware trigger edge or a software trigger. The tick is the same prescaled tick that drives the main delay counter. The enable, mode select and interval value are static configuration fields. The output is registered, so every result appears one clock after the input cycle that causes it.

Top module: `interval_trig_gen`

## Requirements
- R1: While `enable_i` is 0 no pulse is produced, and the counter is cleared and disarmed. After re-enabling, ticks produce no pulse until a start pulse arrives.
- R2: In counter mode, a start pulse clears the count to 0 and arms the counter. A tick in the same cycle as a start is not counted. A start in the middle of a period restarts the period from zero.
- R3: In counter mode, with the counter armed and interval N ≥ 1, the count advances on each cycle with `tick_i` high. The Nth tick after the start, and every Nth tick after that, makes `trig_o` high for exactly the one following clock. After each pulse the count returns to 0 and the counter keeps running.
- R4: After reset, the counter is disarmed, and ticks alone produce no pulse.
- R5: An interval value of 0 suppresses all pulses in counter mode.
- R6: In bypass mode (`ext_mode_i` = 1), each 0-to-1 transition of `ext_trig_i` gives exactly one pulse, one clock later, however long the line stays high. A line that was already high when the block was enabled gives no pulse. `start_i` and `tick_i` have no effect in this mode.
- R7: In counter mode, `ext_trig_i` has no effect on `trig_o`.
- R8: Bypass mode disarms the counter. On return to counter mode, ticks produce no pulse until a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Enables the trigger output |
| ext_mode_i | input | 1 | 0: interval counter source, 1: external edge bypass |
| interval_i | input | CNT_W | Ticks per period; 0 suppresses counter pulses |
| tick_i | input | 1 | Prescaled count tick, one cycle wide |
| start_i | input | 1 | Start pulse that clears and arms the counter |
| ext_trig_i | input | 1 | External trigger line used in bypass mode |
| trig_o | output | 1 | Single-cycle trigger pulse |

## Verification
The output of each source passes through exactly one register. A pulse is therefore due in the cycle after the input cycle that carries the Nth tick, or the rising edge of the external line. In the same way, the effect of a start pulse, a disable or a mode change is visible in the cycle after it is applied. The bench drives every input just after a falling edge. It reads `trig_o` at the next falling edge and compares it with the value due for those inputs. The expected pulse positions for each interval and tick spacing are computed as multiples of N in the count of ticks since the start.

// File: rtl/itg_pkg.sv
package itg_pkg;

    localparam int unsigned ITG_CNT_W = 16;

    typedef enum logic {
        SRC_COUNTER  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } itg_src_e;

endpackage

// File: rtl/itg_counter.sv
module itg_counter #(
    parameter int unsigned CNT_W = itg_pkg::ITG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] interval,
    input  logic             tick,
    input  logic             start,
    output logic             hit
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             hit;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [CNT_W:0] next_cnt;

    always_comb begin
        s_d      = s_q;
        s_d.hit  = 1'b0;
        next_cnt = {1'b0, s_q.cnt} + 1'b1;
        if (!run_en) begin
            s_d.armed = 1'b0;
            s_d.cnt   = '0;
        end else if (start) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (tick && s_q.armed && (interval != '0)) begin
            if (next_cnt >= {1'b0, interval}) begin
                s_d.hit = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = next_cnt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit = s_q.hit;

endmodule

// File: rtl/itg_edge.sv
module itg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_en,
    input  logic line,
    output logic pulse
);

    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d.prev  = line;
        s_d.pulse = pass_en && line && !s_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.pulse;

endmodule

// File: rtl/interval_trig_gen.sv
module interval_trig_gen #(
    parameter int unsigned CNT_W = itg_pkg::ITG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             ext_mode_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             ext_trig_i,
    output logic             trig_o
);

    import itg_pkg::*;

    itg_src_e src;
    logic     cnt_run;
    logic     edge_run;
    logic     cnt_hit;
    logic     edge_hit;

    always_comb begin
        src      = itg_src_e'(ext_mode_i);
        cnt_run  = enable_i && (src == SRC_COUNTER);
        edge_run = enable_i && (src == SRC_EXTERNAL);
    end

    itg_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (cnt_run),
        .interval (interval_i),
        .tick     (tick_i),
        .start    (start_i),
        .hit      (cnt_hit)
    );

    itg_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass_en (edge_run),
        .line    (ext_trig_i),
        .pulse   (edge_hit)
    );

    assign trig_o = cnt_hit | edge_hit;

endmodule

// File: rtl/itg_checker.sv
module itg_checker #(
    parameter int unsigned CNT_W = itg_pkg::ITG_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             ext_mode_i,
    input logic [CNT_W-1:0] interval_i,
    input logic             tick_i,
    input logic             start_i,
    input logic             ext_trig_i,
    input logic             trig_o
);

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable_i) |-> !trig_o); // R1

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i && !ext_mode_i) |-> !trig_o); // R2

    AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(!ext_mode_i)) |-> $past(tick_i)); // R3

    AST_ZERO_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ext_mode_i && (interval_i == '0)) |-> !trig_o); // R5

    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(ext_mode_i)) |-> $past(ext_trig_i)); // R6

endmodule

bind interval_trig_gen itg_checker #(.CNT_W(CNT_W)) u_itg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .ext_mode_i (ext_mode_i),
    .interval_i (interval_i),
    .tick_i     (tick_i),
    .start_i    (start_i),
    .ext_trig_i (ext_trig_i),
    .trig_o     (trig_o)
);

// File: tb/interval_trig_gen_bench.sv
`timescale 1ns/1ps
module interval_trig_gen_bench;

    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable_i = 1'b0;
    logic         ext_mode_i = 1'b0;
    logic [W-1:0] interval_i = '0;
    logic         tick_i = 1'b0;
    logic         start_i = 1'b0;
    logic         ext_trig_i = 1'b0;
    logic         trig_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    interval_trig_gen #(.CNT_W(W)) u_interval_trig_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .ext_mode_i (ext_mode_i),
        .interval_i (interval_i),
        .tick_i     (tick_i),
        .start_i    (start_i),
        .ext_trig_i (ext_trig_i),
        .trig_o     (trig_o)
    );

    task automatic step(input logic tk, input logic st, input logic ex,
                        input logic exp, input string tag);
        tick_i     = tk;
        start_i    = st;
        ext_trig_i = ex;
        @(negedge clk);
        checks++;
        if (trig_o !== exp) begin
            failures++;
            $display("FAIL %s: trig_o=%b expected=%b at %0t", tag, trig_o, exp, $time);
        end
    endtask

    initial begin
        #(8ns * 150000);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt;
        logic tk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (trig_o !== 1'b0) begin
            failures++;
            $display("FAIL R4 reset: trig_o=%b expected=0", trig_o);
        end

        // R4: enabled but never started
        enable_i = 1'b1; interval_i = 16'd2;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R4");

        // R3: sweep interval and tick spacing
        for (int n = 1; n <= 5; n++) begin
            for (int tp = 1; tp <= 3; tp++) begin
                interval_i = W'(n);
                step(1'b0, 1'b1, 1'b0, 1'b0, "R2");
                cnt = 0;
                for (int i = 0; i < 24; i++) begin
                    tk = ((i % tp) == tp - 1);
                    if (tk) cnt++;
                    step(tk, 1'b0, 1'b0, tk && (cnt % n == 0), "R3");
                end
            end
        end

        // R2: start and tick together, tick not counted
        interval_i = 16'd1;
        step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R2");

        // R2: restart in mid-period
        interval_i = 16'd4;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R2");

        // R7: external line ignored in counter mode, mid-period
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, i[0], 1'b0, "R7");

        // R5: zero interval
        interval_i = 16'd0;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R5");

        // R1: disable mid-count, then re-enable without start
        interval_i = 16'd3;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        enable_i = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R1");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        enable_i = 1'b1;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");

        // R6: bypass mode, edges of several widths, start and tick ignored
        ext_mode_i = 1'b1;
        for (int hi = 1; hi <= 4; hi++) begin
            step(1'b1, 1'b1, 1'b1, 1'b1, "R6");
            for (int j = 1; j < hi; j++) step(1'b1, 1'b0, 1'b1, 1'b0, "R6");
            step(1'b1, 1'b1, 1'b0, 1'b0, "R6");
            step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
        end
        // R6: line already high at enable gives no pulse
        enable_i = 1'b0;
        step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
        enable_i = 1'b1;
        step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R6");

        // R8: back to counter mode, disarmed until start
        ext_mode_i = 1'b0; interval_i = 16'd1;
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule